// File: doc/BRIEF.md
# Maskable CRC-64 Flow Key Hasher

This block turns the key fields of a packet header into a compact flow identifier. The two IP addresses, the two transport ports and the protocol number arrive as a stream of 32-bit words, one word per clock. A start marker opens a key and a last marker closes it. A CRC-64 engine folds each word into its state in a single cycle. When the last word has been absorbed, the upper 57 bits of the CRC state are presented as the flow identifier, with a valid strobe.

Each word comes with a byte mask. A set mask bit forces the matching byte to zero before it reaches the CRC. Flows that differ only in masked bytes therefore fall together into one coarser flow. The CRC starts from a seed register rather than a fixed constant, so outside parties cannot predict the identifiers. The seed is meant to be written with a random value once at startup. The upstream parser pads every key to a fixed word count: 10 words for IPv4 and 34 for IPv6. As a result, equal keys always produce an identical hash.

Top module: `flow_key_hasher`

## Requirements
- R1: While reset is asserted, `busy_o` and `hash_valid_o` are 0 and `hash_o` is all zeros. The seed register resets to the parameter `SEED_RST`, which defaults to all ones.
- R2: Each accepted word is absorbed MSB first (bit 31 first) into a 64-bit CRC with polynomial `POLY`, which defaults to 0x42F0E1EBA9EA3693. The shift is to the left, and the polynomial is XORed in when the bit leaving bit 63, XORed with the data bit, is 1. A word carrying the start marker starts from the seed register instead of the running state.
- R3: `hash_valid_o` is high for exactly the cycle after the edge that accepts a last word. In that cycle `hash_o` equals bits 63..7 of the final CRC state. At all other times `hash_o` holds its value.
- R4: Mask bit k set forces data bits 8k+7..8k of that word to zero before hashing. A key masked this way hashes the same as the same key with those bytes already zero.
- R5: A seed write (`seed_we_i`) takes effect when the engine is idle and no word is presented in the same cycle. The written value is used as the start state of the next key.
- R6: A seed write while `busy_o` is high, or while a word is presented, is ignored.
- R7: A word with the start marker is always accepted and restarts hashing from the seed, even in the middle of a key. A word without the start marker while idle is ignored: no hash results and `busy_o` stays low.
- R8: A single word carrying both markers produces a hash in the next cycle, and `busy_o` stays low.
- R9: `busy_o` rises after a start word without the last marker is accepted. It falls after a last word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seed_we_i | input | 1 | Seed register write request |
| seed_i | input | 64 | Seed value to load |
| word_valid_i | input | 1 | A key word is presented |
| word_first_i | input | 1 | Word is the first of a key |
| word_last_i | input | 1 | Word is the last of a key |
| word_i | input | 32 | Key word data |
| byte_mask_i | input | 4 | Per-byte zeroing mask for the word |
| busy_o | output | 1 | A key is in progress |
| hash_valid_o | output | 1 | Flow identifier valid strobe |
| hash_o | output | 57 | Truncated flow identifier |

## Verification
The bench builds the block with its default parameters: a 64-bit state, 32-bit words, a 57-bit identifier and the standard polynomial. This lets both the 10-word and the 34-word key lengths run against a bit-serial reference model that is compared on every clock. The reset seed, a written seed and a seed write attempted mid-key are all exercised. The sequences include back-to-back keys, restarts mid-key, stray words and single-word keys. Masked keys are compared against hand-zeroed keys, which shows that aggregation works without reading any internal state.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
  localparam int unsigned CRC_W_DEF  = 64;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned HASH_W_DEF = 57;
  localparam logic [63:0] POLY_DEF     = 64'h42F0_E1EB_A9EA_3693;
  localparam logic [63:0] SEED_RST_DEF = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fh_state_e;
endpackage

// File: rtl/fh_byte_mask.sv
module fh_byte_mask #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NBYTES = WORD_W / 8
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [NBYTES-1:0] mask_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign word_o[8*b +: 8] = mask_i[b] ? 8'h00 : word_i[8*b +: 8];
  end
endmodule

// File: rtl/fh_crc_step.sv
module fh_crc_step #(
  parameter int unsigned CRC_W  = 64,
  parameter int unsigned WORD_W = 32,
  parameter logic [CRC_W-1:0] POLY = '0
) (
  input  logic [CRC_W-1:0]  state_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [CRC_W-1:0]  state_o
);
  logic [WORD_W:0][CRC_W-1:0] chain;
  assign chain[0] = state_i;

  // one stage per data bit, MSB first
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][CRC_W-1] ^ data_i[WORD_W-1-i];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign state_o = chain[WORD_W];
endmodule

// File: rtl/fh_seed_reg.sv
module fh_seed_reg #(
  parameter int unsigned CRC_W = 64,
  parameter logic [CRC_W-1:0] SEED_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             busy_i,
  input  logic             word_i,
  input  logic [CRC_W-1:0] seed_i,
  output logic [CRC_W-1:0] seed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        seed_o <= SEED_RST;
    else if (we_i && !busy_i && !word_i) seed_o <= seed_i;
  end

  assert_seed_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i || word_i) |=> $stable(seed_o));
endmodule

// File: rtl/flow_key_hasher.sv
module flow_key_hasher
  import flow_hash_pkg::*;
#(
  parameter int unsigned CRC_W  = CRC_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned HASH_W = HASH_W_DEF,
  parameter logic [CRC_W-1:0] POLY     = POLY_DEF,
  parameter logic [CRC_W-1:0] SEED_RST = SEED_RST_DEF,
  localparam int unsigned NBYTES = WORD_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_we_i,
  input  logic [CRC_W-1:0]  seed_i,
  input  logic              word_valid_i,
  input  logic              word_first_i,
  input  logic              word_last_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [NBYTES-1:0] byte_mask_i,
  output logic              busy_o,
  output logic              hash_valid_o,
  output logic [HASH_W-1:0] hash_o
);
  fh_state_e        state_q;
  logic [CRC_W-1:0] crc_q, crc_start, crc_next, seed_q;
  logic [WORD_W-1:0] word_m;
  logic             accept, finish;

  assign accept    = word_valid_i && (word_first_i || state_q == ST_BUSY);
  assign finish    = accept && word_last_i;
  assign crc_start = word_first_i ? seed_q : crc_q;
  assign busy_o    = (state_q == ST_BUSY);

  fh_byte_mask #(.WORD_W(WORD_W)) u_mask (
    .word_i(word_i), .mask_i(byte_mask_i), .word_o(word_m)
  );

  fh_crc_step #(.CRC_W(CRC_W), .WORD_W(WORD_W), .POLY(POLY)) u_step (
    .state_i(crc_start), .data_i(word_m), .state_o(crc_next)
  );

  fh_seed_reg #(.CRC_W(CRC_W), .SEED_RST(SEED_RST)) u_seed (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(seed_we_i), .busy_i(busy_o),
    .word_i(word_valid_i), .seed_i(seed_i), .seed_o(seed_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      crc_q        <= '0;
      hash_valid_o <= 1'b0;
      hash_o       <= '0;
    end else begin
      hash_valid_o <= finish;
      if (accept) begin
        crc_q   <= crc_next;
        state_q <= word_last_i ? ST_IDLE : ST_BUSY;
      end
      if (finish) hash_o <= crc_next[CRC_W-1 -: HASH_W];
    end
  end

  assert_valid_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o |-> $past(word_valid_i && word_last_i && (word_first_i || busy_o)));

  assert_hash_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i && word_last_i && (word_first_i || busy_o)) |=> $stable(hash_o));

  assert_stray_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && word_valid_i && !word_first_i) |=> (!hash_valid_o && !busy_o));

  assert_busy_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(word_valid_i && word_first_i && !word_last_i));

  assert_single_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_first_i && word_last_i) |=> (hash_valid_o && !busy_o));
endmodule

// File: tb/flow_key_hasher_test.sv
module flow_key_hasher_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_we = 1'b0;
  logic [63:0] seed = '0;
  logic        wv = 1'b0, wf = 1'b0, wl = 1'b0;
  logic [31:0] wd = '0;
  logic [3:0]  wm = '0;
  logic        busy, hv;
  logic [56:0] hash;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_key_hasher uut (
    .clk_i(clk), .rst_ni(rst_n), .seed_we_i(seed_we), .seed_i(seed),
    .word_valid_i(wv), .word_first_i(wf), .word_last_i(wl),
    .word_i(wd), .byte_mask_i(wm),
    .busy_o(busy), .hash_valid_o(hv), .hash_o(hash)
  );

  // reference model
  longint unsigned m_seed, m_crc;
  bit              m_busy, m_valid;
  logic [56:0]     m_hash;

  function automatic longint unsigned ref_crc(longint unsigned c, logic [31:0] w);
    longint unsigned r = c;
    for (int i = 31; i >= 0; i--) begin
      bit top = r[63] ^ w[i];
      r = r << 1;
      if (top) r = r ^ 64'h42F0E1EBA9EA3693;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_seed = '1; m_crc = 0; m_busy = 0; m_valid = 0; m_hash = '0;
    end else begin
      logic [31:0] dm;
      longint unsigned nxt;
      bit acc;
      dm = wd;
      for (int b = 0; b < 4; b++) if (wm[b]) dm[8*b +: 8] = 8'h00;
      acc = wv && (wf || m_busy);
      nxt = ref_crc(wf ? m_seed : m_crc, dm);
      if (seed_we && !m_busy && !wv) m_seed = seed;
      m_valid = acc && wl;
      if (acc) begin
        m_crc = nxt;
        m_busy = !wl;
        if (wl) m_hash = nxt[63:7];
      end
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, "hash_valid_o", 64'(hv), 64'(m_valid));
    check("R9", "busy_o", 64'(busy), 64'(m_busy));
    check(cur_req, "hash_o", 64'(hash), 64'(m_hash));
  end

  task automatic drive(bit v, bit f, bit l, logic [31:0] d, logic [3:0] m);
    wv = v; wf = f; wl = l; wd = d; wm = m;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    wv = 0; wf = 0; wl = 0; wd = '0; wm = '0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] key_word(logic [31:0] base, int i);
    return base ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  // sends an n-word key; word zidx gets mask mpat, or has bytes zpat zeroed
  task automatic send_key(int n, logic [31:0] base, int zidx, logic [3:0] mpat,
                          logic [3:0] zpat, output logic [56:0] h);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d = key_word(base, i);
      logic [3:0]  m = '0;
      if (i == zidx) begin
        m = mpat;
        for (int b = 0; b < 4; b++) if (zpat[b]) d[8*b +: 8] = 8'h00;
      end
      drive(1, i == 0, i == n - 1, d, m);
    end
    idle(0);
    h = hash;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [56:0] h_a, h_b, h_c, h_d;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "reset hash", 64'(hash), 64'h0);
    check("R1", "reset valid", 64'(hv), 64'h0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    send_key(10, 32'hC0A8_0001, -1, 4'h0, 4'h0, h_a);
    check("R3", "strobe after last", 64'(hv), 64'h1);
    idle(2);
    send_key(10, 32'hC0A8_0001, -1, 4'h0, 4'h0, h_b);
    check("R2", "same key same hash", 64'(h_b), 64'(h_a));
    send_key(34, 32'h2001_0DB8, -1, 4'h0, 4'h0, h_c);   // back-to-back IPv6
    check("R2", "v6 key differs", 64'(h_c != h_a), 64'h1);
    idle(3);

    cur_req = "R4";
    send_key(10, 32'h0A00_0005, 8, 4'b0011, 4'h0, h_c);
    idle(1);
    send_key(10, 32'h0A00_0005, 8, 4'b0000, 4'b0011, h_d);
    check("R4", "masked equals zeroed", 64'(h_c), 64'(h_d));
    send_key(10, 32'h0A00_0005, 8, 4'b1111, 4'h0, h_c);
    idle(1);
    send_key(10, 32'h0A00_0005, 8, 4'b0000, 4'b1111, h_d);
    check("R4", "full mask equals zeroed", 64'(h_c), 64'(h_d));
    idle(2);

    cur_req = "R5";
    seed = 64'h0123_4567_89AB_CDEF; seed_we = 1;
    @(negedge clk);
    seed_we = 0;
    send_key(10, 32'hC0A8_0001, -1, 4'h0, 4'h0, h_b);
    check("R5", "new seed changes hash", 64'(h_b != h_a), 64'h1);
    idle(2);

    cur_req = "R6";
    drive(1, 1, 0, 32'h1111_2222, 4'h0);
    seed = 64'hDEAD_BEEF_0000_0001; seed_we = 1;
    drive(1, 0, 0, 32'h3333_4444, 4'h0);
    idle(1);
    drive(1, 0, 1, 32'h5555_6666, 4'h0);
    seed_we = 0;
    idle(1);
    seed_we = 1;                             // with a word presented
    drive(1, 1, 1, 32'h7777_8888, 4'h0);
    seed_we = 0;
    idle(1);
    send_key(10, 32'hC0A8_0001, -1, 4'h0, 4'h0, h_c);
    check("R6", "seed kept", 64'(h_c), 64'(h_b));
    idle(2);

    cur_req = "R7";
    drive(1, 0, 0, 32'hAAAA_0000, 4'h0);
    drive(1, 0, 1, 32'hBBBB_0000, 4'h0);
    check("R7", "stray word no strobe", 64'(hv), 64'h0);
    drive(1, 1, 0, 32'h9999_0000, 4'h0);
    drive(1, 0, 0, 32'h8888_0000, 4'h0);
    send_key(10, 32'hC0A8_0001, -1, 4'h0, 4'h0, h_d);
    check("R7", "restart ignores partial", 64'(h_d), 64'(h_b));
    idle(2);

    cur_req = "R8";
    drive(1, 1, 1, 32'hFEED_F00D, 4'h0);
    check("R8", "single word strobe", 64'(hv), 64'h1);
    drive(1, 1, 1, 32'hFEED_F00E, 4'h2);
    check("R8", "busy low", 64'(busy), 64'h0);
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule